// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block drives one Clause 22 management transaction at a time on the MDC and MDIO lines of an Ethernet PHY. Software builds the whole 32-bit frame word in a single register. That word holds the start pattern, the operation, the PHY and register addresses, the turnaround code and the 16 data bits. A write to the frame register starts the transaction, provided the management port has first been switched on by its enable bit. The engine sends 32 preamble ones and then the frame word, most significant bit first. MDC is derived from the system clock through a divider that software selects.

For a read operation, the engine releases MDIO from the turnaround onward. It samples the 16 bits the PHY returns and puts them into the low half of the frame register when the frame ends. Software polls an idle flag to learn when the result is ready. A returned value of all ones means no PHY answered at that address.

A plain register port with write strobe, 2-bit address and combinational read data gives access to the enable, divider, frame and status registers. The MDIO pad is split into an output, an output enable and an input, so the tristate buffer is placed at chip level.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control and divider registers read 0, the frame register reads 0, the status register reads 1 (idle), MDC is low, MDIO output is 1 and the output enable is 0.
- R2: Register map on host_addr: 0 = control (bit 0 port enable), 1 = divider select (bits 1:0), 2 = frame word, 3 = status (bit 0 idle, read-only); unused bits read 0 and writes to address 3 have no effect.
- R3: A write to the frame register while the port is enabled and idle starts a transaction; the idle bit reads 0 on the next cycle and returns to 1 after exactly 64 MDC periods (64 rising MDC edges).
- R4: The MDC period equals 8 << sel system clock cycles for divider select sel in 0..3, with MDC high for half the period; MDC stays low while idle.
- R5: The serial stream seen at successive MDC rising edges is 32 ones followed by frame bits 31 down to 0; MDIO output changes only in the cycle MDC falls.
- R6: When frame bits 29:28 equal 2'b10 (read), the output enable drops from serial position 46 (the turnaround, frame bit 17) to the end of the frame; any other code drives all 64 positions.
- R7: For a read, the 16 MDIO input bits sampled at MDC rises 48..63 (first sample most significant) replace frame bits 15:0 when idle returns, bits 31:16 unchanged; a PHY that answers with all ones yields 0xFFFF; a write frame leaves the register unchanged.
- R8: A frame register write while the port enable bit is 0 is ignored: no MDC activity, idle stays 1, the register keeps its previous value.
- R9: A frame register write while a transaction is in progress is ignored: the running frame completes unchanged and the register keeps the first word.
- R10: The output enable is 0 whenever the engine is idle and 1 through preamble and all non-read positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from pad |

## Verification
The frame path is run with write and read words at each of the four divider settings. This separates the four period lengths and shows that the duty cycle stays at one half. Read frames are answered with a mixed pattern, with a single low-order one, and with all ones for an absent PHY. These answers show the bit order of the capture, that the upper half of the word is kept and that the released window starts exactly at the turnaround. Write frames with extreme address and data values are compared bit by bit against the expected serial stream. Directed cases cover the register map at reset, writes made while the port is disabled, and a second frame write made in the middle of a running transaction.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_LEN  = 32;
    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 2;
    localparam int BIT_CNT  = PRE_LEN + FRAME_W;
    localparam int IDX_W    = $clog2(BIT_CNT);

    // operation field position inside the frame word
    localparam int OP_HI = 29;
    localparam int OP_LO = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    // serial positions (preamble counted) of turnaround start and data start
    localparam int TA_FRAME_BIT = 17;
    localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(PRE_LEN + FRAME_W - 1 - TA_FRAME_BIT);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(BIT_CNT - DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BIT_CNT - 1);

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_CFG   = 2'd1,
        ADDR_FRAME = 2'd2,
        ADDR_STAT  = 2'd3
    } host_addr_e;

    typedef struct packed {
        logic                 en;
        logic [SEL_W-1:0]     sel;
        logic [FRAME_W-1:0]   frame;
    } reg_st_t;

    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_W-1:0]   shreg;
        logic                 is_rd;
        logic [DATA_W-1:0]    cap;
        logic                 mdio;
        logic                 oe;
        logic                 done;
    } shift_st_t;

endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int CNT_W      = BASE_LOG2 + (1 << SEL_W) - 1;
    localparam int SHIFT_BASE = BASE_LOG2 - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t          div_d, div_q;
    logic [CNT_W-1:0] half_m1;
    logic             toggle;

    always_comb begin
        half_m1   = (CNT_W'(1) << (SHIFT_BASE + int'(sel))) - CNT_W'(1);
        toggle    = run && (div_q.cnt == half_m1);
        rise_tick = toggle && !div_q.mdc;
        fall_tick = toggle && div_q.mdc;

        div_d = div_q;
        if (!run) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (toggle) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mdc = div_q.mdc;

endmodule

// File: rtl/mdio_mgmt_shifter.sv
module mdio_mgmt_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FRAME_W-1:0]  frame_in,
    input  logic                rise_tick,
    input  logic                fall_tick,
    input  logic                mdio_in,
    output logic                busy,
    output logic                done,
    output logic                is_rd,
    output logic [DATA_W-1:0]   cap,
    output logic                mdio_out,
    output logic                mdio_oe
);

    shift_st_t          sh_d, sh_q;
    logic [IDX_W-1:0]   nidx;
    logic [FRAME_W-1:0] sh_nx;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        nidx      = sh_q.idx + IDX_W'(1);
        sh_nx     = sh_q.shreg;

        if (!sh_q.busy) begin
            if (start) begin
                sh_d.busy  = 1'b1;
                sh_d.idx   = '0;
                sh_d.shreg = frame_in;
                sh_d.is_rd = (frame_in[OP_HI:OP_LO] == OP_READ);
                sh_d.cap   = '0;
                sh_d.mdio  = 1'b1;
                sh_d.oe    = 1'b1;
            end
        end else begin
            // sample on the rising MDC edge inside the data window of a read
            if (rise_tick && sh_q.is_rd && (sh_q.idx >= IDX_DATA)) begin
                sh_d.cap = {sh_q.cap[DATA_W-2:0], mdio_in};
            end
            // advance on the falling MDC edge
            if (fall_tick) begin
                if (sh_q.idx == IDX_LAST) begin
                    sh_d.busy = 1'b0;
                    sh_d.done = 1'b1;
                    sh_d.mdio = 1'b1;
                    sh_d.oe   = 1'b0;
                end else begin
                    if (nidx > IDX_PRE) begin
                        sh_nx = {sh_q.shreg[FRAME_W-2:0], 1'b0};
                    end
                    sh_d.idx   = nidx;
                    sh_d.shreg = sh_nx;
                    sh_d.mdio  = (nidx < IDX_PRE) ? 1'b1 : sh_nx[FRAME_W-1];
                    sh_d.oe    = !(sh_q.is_rd && (nidx >= IDX_TA));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.mdio <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy     = sh_q.busy;
    assign done     = sh_q.done;
    assign is_rd    = sh_q.is_rd;
    assign cap      = sh_q.cap;
    assign mdio_out = sh_q.mdio;
    assign mdio_oe  = sh_q.oe;

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          addr,
    input  logic [FRAME_W-1:0]  wdata,
    input  logic                busy,
    input  logic                done,
    input  logic                is_rd,
    input  logic [DATA_W-1:0]   cap,
    output logic                port_en,
    output logic [SEL_W-1:0]    div_sel,
    output logic [FRAME_W-1:0]  frame,
    output logic                start,
    output logic [FRAME_W-1:0]  rdata
);

    reg_st_t    rg_d, rg_q;
    host_addr_e sel_addr;

    always_comb begin
        sel_addr = host_addr_e'(addr);
        start    = we && (sel_addr == ADDR_FRAME) && rg_q.en && !busy;

        rg_d = rg_q;
        // returned read data lands in the low half at frame end
        if (done && is_rd) begin
            rg_d.frame[DATA_W-1:0] = cap;
        end
        if (we) begin
            case (sel_addr)
                ADDR_CTRL:  rg_d.en  = wdata[0];
                ADDR_CFG:   rg_d.sel = wdata[SEL_W-1:0];
                ADDR_FRAME: if (start) rg_d.frame = wdata;
                default:    ;
            endcase
        end

        case (sel_addr)
            ADDR_CTRL:  rdata = {{(FRAME_W-1){1'b0}}, rg_q.en};
            ADDR_CFG:   rdata = {{(FRAME_W-SEL_W){1'b0}}, rg_q.sel};
            ADDR_FRAME: rdata = rg_q.frame;
            default:    rdata = {{(FRAME_W-1){1'b0}}, ~busy};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign port_en = rg_q.en;
    assign div_sel = rg_q.sel;
    assign frame   = rg_q.frame;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [1:0]   host_addr,
    input  logic [31:0]  host_wdata,
    output logic [31:0]  host_rdata,
    output logic         mdc_o,
    output logic         mdio_o,
    output logic         mdio_oe_o,
    input  logic         mdio_i
);

    logic                busy;
    logic                done;
    logic                is_rd;
    logic [DATA_W-1:0]   cap;
    logic                ctrl_en;
    logic [SEL_W-1:0]    div_sel;
    logic [FRAME_W-1:0]  frame_q;
    logic                start;
    logic                rise_tick;
    logic                fall_tick;

    mdio_mgmt_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (host_we),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .busy    (busy),
        .done    (done),
        .is_rd   (is_rd),
        .cap     (cap),
        .port_en (ctrl_en),
        .div_sel (div_sel),
        .frame   (frame_q),
        .start   (start),
        .rdata   (host_rdata)
    );

    mdio_mgmt_clkdiv #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (3)
    ) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sel       (div_sel),
        .mdc       (mdc_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_mgmt_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_in  (host_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_i),
        .busy      (busy),
        .done      (done),
        .is_rd     (is_rd),
        .cap       (cap),
        .mdio_out  (mdio_o),
        .mdio_oe   (mdio_oe_o)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
    import mdio_mgmt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic [1:0]         host_addr,
    input logic               mdc_o,
    input logic               mdio_o,
    input logic               mdio_oe_o,
    input logic               busy,
    input logic               port_en,
    input logic [FRAME_W-1:0] frame_q
);

    logic frame_wr;
    assign frame_wr = host_we && (host_addr == ADDR_FRAME);

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && port_en && !busy) |=> busy);  // R3

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc_o);  // R4

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc_o));  // R5

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe_o) |-> ($fell(mdc_o) || $rose(busy)));  // R6

    AST_DISABLED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !port_en && !busy) |=> (!busy && $stable(frame_q)));  // R8

    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && busy) |=> ($stable(frame_q) || !busy));  // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe_o);  // R10

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .busy      (busy),
    .port_en   (ctrl_en),
    .frame_q   (frame_q)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_FRM  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    // {divider select, frame word, PHY answer}
    localparam int NVEC = 6;
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd0, 32'h5092ABCD, 16'h0000},
        {2'd1, 32'h61860000, 16'h1234},
        {2'd2, 32'h6F8A0000, 16'hFFFF},
        {2'd3, 32'h50028000, 16'h0000},
        {2'd0, 32'h62FE5555, 16'h0001},
        {2'd1, 32'h5FFE0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    wire  [31:0] host_rdata;
    wire         mdc_o;
    wire         mdio_o;
    wire         mdio_oe_o;
    logic        mdio_i = 1'b1;

    always #5ns clk = ~clk;

    mdio_mgmt_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mdc_o      (mdc_o),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .mdio_i     (mdio_i)
    );

    int          checks = 0;
    int          fails = 0;
    longint      cyc = 0;
    bit          finished = 0;

    // MDC-side monitor and PHY model
    int          rcnt = 0;
    int          base = 0;
    logic [15:0] cur_resp = 16'hFFFF;
    logic        smp_bit [0:1023];
    logic        smp_oe  [0:1023];
    longint      t_rise  [0:1023];
    longint      t_fall  [0:1023];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc_o) begin
        if (rcnt < 1024) begin
            smp_bit[rcnt] = mdio_o;
            smp_oe[rcnt]  = mdio_oe_o;
            t_rise[rcnt]  = cyc;
        end
        rcnt = rcnt + 1;
    end

    always @(negedge mdc_o) begin
        int k;
        k = rcnt - base;
        if (rcnt > 0 && rcnt <= 1024) t_fall[rcnt-1] = cyc;
        if (k >= 48 && k < 64) mdio_i = cur_resp[63-k];
        else                   mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1ns;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 20000; n++) begin
            rd(A_STAT, s);
            if (s[0]) break;
        end
    endtask

    // compare the 64 recorded positions starting at b against a frame word
    task automatic check_stream(input int b, input logic [31:0] fr, input bit rdop,
                                input string tag);
        int bit_err = 0;
        int oe_err = 0;
        for (int i = 0; i < 64; i++) begin
            logic eb;
            logic eo;
            eb = (i < 32) ? 1'b1 : fr[63-i];
            eo = !(rdop && i >= 46);
            if (eo && smp_bit[b+i] !== eb) bit_err++;
            if (smp_oe[b+i] !== eo) oe_err++;
        end
        chk(bit_err == 0, "R5", {tag, " serial bit mismatches"}, bit_err, 0);
        chk(oe_err == 0, rdop ? "R6" : "R10", {tag, " output enable mismatches"}, oe_err, 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);

        // R1: reset state, sampled while reset is held and after release
        chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0 && mdio_o == 1'b1, "R1",
            "pins in reset {mdc,oe,mdio}", {mdc_o, mdio_oe_o, mdio_o}, 3'b001);
        rst_n = 1'b1;
        rd(A_CTRL, v); chk(v == 32'h0, "R1", "control after reset", v, 0);
        rd(A_CFG,  v); chk(v == 32'h0, "R1", "divider after reset", v, 0);
        rd(A_FRM,  v); chk(v == 32'h0, "R1", "frame after reset", v, 0);
        rd(A_STAT, v); chk(v == 32'h1, "R1", "status after reset", v, 1);

        // R2: register map and read-only status
        wr(A_CFG, 32'hFFFF_FFF3);
        rd(A_CFG, v); chk(v == 32'h3, "R2", "divider readback", v, 3);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); chk(v == 32'h0, "R2", "control bit 0 only", v, 0);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk(v == 32'h1, "R2", "control readback", v, 1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk(v == 32'h1, "R2", "status is read-only", v, 1);
        wr(A_CTRL, 32'h0);

        // vector table: one frame per entry
        for (int e = 0; e < NVEC; e++) begin
            logic [1:0]  sel;
            logic [31:0] fr;
            logic [15:0] resp;
            logic [31:0] exp_fr;
            bit          rdop;
            longint      ratio;
            sel   = VEC[e][49:48];
            fr    = VEC[e][47:16];
            resp  = VEC[e][15:0];
            rdop  = (fr[29:28] == 2'b10);
            ratio = longint'(8) << sel;

            wr(A_CFG, {30'h0, sel});
            wr(A_CTRL, 32'h1);
            base = rcnt;
            cur_resp = resp;
            wr(A_FRM, fr);
            rd(A_STAT, v); chk(v[0] == 1'b0, "R3", "idle low after start", v[0], 0);
            wait_idle();
            chk(rcnt - base == 64, "R3", "MDC rises per frame", rcnt - base, 64);
            chk(t_rise[base+1] - t_rise[base] == ratio, "R4", "MDC period",
                t_rise[base+1] - t_rise[base], ratio);
            chk(t_fall[base] - t_rise[base] == ratio / 2, "R4", "MDC high time",
                t_fall[base] - t_rise[base], ratio / 2);
            check_stream(base, fr, rdop, rdop ? "read" : "write");
            exp_fr = rdop ? {fr[31:16], resp} : fr;
            rd(A_FRM, v); chk(v == exp_fr, "R7", "frame after completion", v, exp_fr);
            chk(mdio_oe_o == 1'b0 && mdc_o == 1'b0, "R10", "released when idle",
                {mdio_oe_o, mdc_o}, 0);
            wr(A_CTRL, 32'h0);
        end

        // R9: second frame write during a running transaction
        wr(A_CFG, 32'h0);
        wr(A_CTRL, 32'h1);
        base = rcnt;
        cur_resp = 16'hFFFF;
        wr(A_FRM, 32'h5092ABCD);
        repeat (30) @(negedge clk);
        wr(A_FRM, 32'h61860000);
        wait_idle();
        chk(rcnt - base == 64, "R9", "only one frame sent", rcnt - base, 64);
        check_stream(base, 32'h5092ABCD, 1'b0, "busy-write");
        rd(A_FRM, v); chk(v == 32'h5092ABCD, "R9", "frame kept first word", v, 32'h5092ABCD);

        // R8: frame write with the port disabled
        wr(A_CTRL, 32'h0);
        base = rcnt;
        wr(A_FRM, 32'h6F8A0000);
        repeat (40) @(negedge clk);
        rd(A_STAT, v); chk(v[0] == 1'b1, "R8", "idle stays high", v[0], 1);
        chk(rcnt - base == 0, "R8", "no MDC activity", rcnt - base, 0);
        rd(A_FRM, v); chk(v == 32'h5092ABCD, "R8", "frame unchanged", v, 32'h5092ABCD);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule